// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave with 128-Byte Array

This block is the bus-facing half of a small serial memory. It oversamples the two-wire bus lines (SCL, SDA) with the system clock, finds START and STOP conditions, and decodes a device-select byte. The byte carries a fixed type code and the values of three strap pins. When the select byte matches, the slave acknowledges. It then either takes a byte address followed by write data, or returns read data from a 128-byte register file. Reads come from one internal address counter that advances by itself. The same counter serves three read styles: the current-address read, the random read (a dummy write that sets the address, then a repeated START and a read select), and the sequential read.

Each received write byte is handed to an external write-cycle engine as a request carrying address and data. The byte is also committed to the register file at the moment the engine accepts it. The engine reports a busy write cycle on a plain status pin. The slave never drives SDA high. It only asserts an output-enable that pulls the line low.

The write request interface is valid/ready. A request stays on the pins, unchanged, until ready is seen high at a clock edge. A write byte that completes while an earlier request is still waiting is not acknowledged and is dropped. The transaction then ends and the slave waits for the next START.

Top module: `eeprom_i2c_slave`

## Requirements
- R1: A select byte is accepted only when its bits 7..4 equal 1010 and its bits 3..1 equal strap_i[2], strap_i[1], strap_i[0] (bit 3 = strap_i[2]). Bit 0 gives the direction: 1 = read, 0 = write.
- R2: On an accepted select byte, sda_oe_o is high across the whole ninth SCL clock. On any other byte the slave leaves SDA released and ignores the bus until the next START.
- R3: After a write select, the next byte loads the address counter from its bits 6..0 (bit 7 is ignored). Each following byte is acknowledged and issued as one request with the counter value as address, after which the counter advances by one modulo 128.
- R4: wr_valid_o, wr_addr_o and wr_data_o hold steady until wr_ready_i is high at a clock edge, and the array is written at that edge. A write byte that ends while a request is still pending gets no acknowledge, is dropped, and ends the transaction.
- R5: A read select with no byte-address phase returns the byte at the address counter, MSB first, and advances the counter.
- R6: A write select, a byte address, a repeated START and a read select return the byte stored at that address.
- R7: After a master acknowledge (SDA low on the ninth clock), the next byte follows at the incremented address, wrapping from 127 to 0. After a master no-acknowledge, SDA is released and the transfer ends.
- R8: The slave changes SDA only while SCL is low. The first data bit of each read byte is driven after the SCL falling edge that closes the preceding acknowledge.
- R9: A START at any point abandons the transaction in progress, including a partly received byte, and re-arms select decoding. After a STOP the slave answers nothing until a START.
- R10: While busy_i is high, a matching select byte is not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| strap_i | input | 3 | Device address straps, compared with select bits 3..1 |
| busy_i | input | 1 | Write-cycle engine busy; blocks select acknowledge |
| sda_oe_o | output | 1 | Pull SDA low when high |
| wr_valid_o | output | 1 | Write request valid |
| wr_ready_i | input | 1 | Write engine accepts request |
| wr_addr_o | output | 7 | Write request byte address |
| wr_data_o | output | 8 | Write request data byte |

## Verification
A wrong protocol state shows at the ports within one bus bit. A slip in the bit counter or in the state moves the acknowledge off the ninth clock, or makes SDA change while SCL is high, and either is seen by the next sampled bit. A wrong address counter does not fail until the next read byte returns the wrong data, or the next write request carries the wrong address. For that reason the directed sequences write known patterns and read them back across the wrap point, through both the current-address and the random-read paths.

// File: rtl/eeprom_i2c_pkg.sv
package eeprom_i2c_pkg;
  typedef enum logic [3:0] {
    S_IDLE,
    S_SEL,
    S_SEL_ACK,
    S_ADDR,
    S_ADDR_ACK,
    S_WDAT,
    S_WDAT_ACK,
    S_RDAT,
    S_RACK
  } slv_state_e;

  localparam logic [3:0] TYPE_CODE = 4'b1010;
  localparam int unsigned BYTE_W   = 8;
endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int unsigned LAST = SYNC_STAGES;

  logic [LAST:0] scl_sh;
  logic [LAST:0] sda_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
    end else begin
      scl_sh <= {scl_sh[LAST-1:0], scl_i};
      sda_sh <= {sda_sh[LAST-1:0], sda_i};
    end
  end

  logic scl_cur, scl_prev, sda_cur, sda_prev;
  assign scl_cur  = scl_sh[LAST-1];
  assign scl_prev = scl_sh[LAST];
  assign sda_cur  = sda_sh[LAST-1];
  assign sda_prev = sda_sh[LAST];

  assign scl_o      = scl_cur;
  assign sda_o      = sda_cur;
  assign scl_rise_o = !scl_prev && scl_cur;
  assign scl_fall_o = scl_prev && !scl_cur;
  assign start_o    = scl_prev && scl_cur && sda_prev && !sda_cur;
  assign stop_o     = scl_prev && scl_cur && !sda_prev && sda_cur;
endmodule

// File: rtl/eeprom_regfile.sv
module eeprom_regfile #(
  parameter int unsigned AW = 7,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
  import eeprom_i2c_pkg::*;
#(
  parameter int unsigned AW = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic [2:0]        strap_i,
  input  logic              busy_i,
  output logic [AW-1:0]     rd_addr_o,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              wr_valid_o,
  input  logic              wr_ready_i,
  output logic [AW-1:0]     wr_addr_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              sda_oe_o
);
  slv_state_e        state_q;
  logic [2:0]        bit_q;
  logic [BYTE_W-1:0] shreg_q;
  logic              byte_done_q;
  logic              rw_q;
  logic              mack_q;
  logic              oe_q;
  logic [AW-1:0]     addr_q;
  logic              wr_valid_q;
  logic [AW-1:0]     wr_addr_q;
  logic [BYTE_W-1:0] wr_data_q;
  logic              sel_hit;

  assign sel_hit = (shreg_q[7:4] == TYPE_CODE) && (shreg_q[3:1] == strap_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= S_IDLE;
      bit_q       <= '0;
      shreg_q     <= '0;
      byte_done_q <= 1'b0;
      rw_q        <= 1'b0;
      mack_q      <= 1'b0;
      oe_q        <= 1'b0;
      addr_q      <= '0;
      wr_valid_q  <= 1'b0;
      wr_addr_q   <= '0;
      wr_data_q   <= '0;
    end else begin
      if (wr_valid_q && wr_ready_i) wr_valid_q <= 1'b0;
      if (start_ev) begin
        state_q     <= S_SEL;
        bit_q       <= '0;
        byte_done_q <= 1'b0;
        oe_q        <= 1'b0;
      end else if (stop_ev) begin
        state_q     <= S_IDLE;
        byte_done_q <= 1'b0;
        oe_q        <= 1'b0;
      end else begin
        case (state_q)
          S_SEL, S_ADDR, S_WDAT: begin
            if (scl_rise) begin
              shreg_q <= {shreg_q[BYTE_W-2:0], sda_s};
              bit_q   <= bit_q + 3'd1;
              if (bit_q == 3'd7) byte_done_q <= 1'b1;
            end else if (scl_fall && byte_done_q) begin
              byte_done_q <= 1'b0;
              bit_q       <= '0;
              if (state_q == S_SEL) begin
                if (sel_hit && !busy_i) begin
                  oe_q    <= 1'b1;
                  rw_q    <= shreg_q[0];
                  state_q <= S_SEL_ACK;
                end else begin
                  state_q <= S_IDLE;
                end
              end else if (state_q == S_ADDR) begin
                addr_q  <= shreg_q[AW-1:0];
                oe_q    <= 1'b1;
                state_q <= S_ADDR_ACK;
              end else begin
                if (!wr_valid_q) begin
                  wr_valid_q <= 1'b1;
                  wr_addr_q  <= addr_q;
                  wr_data_q  <= shreg_q;
                  addr_q     <= addr_q + 1'b1;
                  oe_q       <= 1'b1;
                  state_q    <= S_WDAT_ACK;
                end else begin
                  state_q <= S_IDLE;
                end
              end
            end
          end
          S_SEL_ACK: begin
            if (scl_fall) begin
              if (rw_q) begin
                shreg_q <= rd_data_i;
                oe_q    <= !rd_data_i[BYTE_W-1];
                addr_q  <= addr_q + 1'b1;
                bit_q   <= '0;
                state_q <= S_RDAT;
              end else begin
                oe_q    <= 1'b0;
                state_q <= S_ADDR;
              end
            end
          end
          S_ADDR_ACK, S_WDAT_ACK: begin
            if (scl_fall) begin
              oe_q    <= 1'b0;
              state_q <= S_WDAT;
            end
          end
          S_RDAT: begin
            if (scl_fall) begin
              if (bit_q == 3'd7) begin
                oe_q    <= 1'b0;
                state_q <= S_RACK;
              end else begin
                bit_q   <= bit_q + 3'd1;
                oe_q    <= !shreg_q[BYTE_W-2];
                shreg_q <= {shreg_q[BYTE_W-2:0], 1'b0};
              end
            end
          end
          S_RACK: begin
            if (scl_rise) begin
              mack_q <= !sda_s;
            end else if (scl_fall) begin
              if (mack_q) begin
                shreg_q <= rd_data_i;
                oe_q    <= !rd_data_i[BYTE_W-1];
                addr_q  <= addr_q + 1'b1;
                bit_q   <= '0;
                state_q <= S_RDAT;
              end else begin
                oe_q    <= 1'b0;
                state_q <= S_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign rd_addr_o  = addr_q;
  assign wr_valid_o = wr_valid_q;
  assign wr_addr_o  = wr_addr_q;
  assign wr_data_o  = wr_data_q;
  assign sda_oe_o   = oe_q;

  // R8
  sda_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(oe_q) |-> !scl_s);

  // R4
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_q && !wr_ready_i) |=> (wr_valid_q && $stable(wr_addr_q) && $stable(wr_data_q)));

  // R10
  busy_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_SEL && byte_done_q && scl_fall && busy_i && !start_ev && !stop_ev) |=> !oe_q);

  // R9
  start_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> (state_q == S_SEL && !oe_q && bit_q == 3'd0));

  // R1
  sel_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_SEL_ACK) |-> (shreg_q[7:4] == TYPE_CODE && shreg_q[3:1] == strap_i));
endmodule

// File: rtl/eeprom_i2c_slave.sv
module eeprom_i2c_slave #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned AW          = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic [2:0]    strap_i,
  input  logic          busy_i,
  output logic          sda_oe_o,
  output logic          wr_valid_o,
  input  logic          wr_ready_i,
  output logic [AW-1:0] wr_addr_o,
  output logic [7:0]    wr_data_o
);
  localparam int unsigned DW = eeprom_i2c_pkg::BYTE_W;

  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_data;

  i2c_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_o      (scl_s),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_ev),
    .stop_o     (stop_ev)
  );

  i2c_slave_fsm #(.AW(AW)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_s      (scl_s),
    .sda_s      (sda_s),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .start_ev   (start_ev),
    .stop_ev    (stop_ev),
    .strap_i    (strap_i),
    .busy_i     (busy_i),
    .rd_addr_o  (rd_addr),
    .rd_data_i  (rd_data),
    .wr_valid_o (wr_valid_o),
    .wr_ready_i (wr_ready_i),
    .wr_addr_o  (wr_addr_o),
    .wr_data_o  (wr_data_o),
    .sda_oe_o   (sda_oe_o)
  );

  eeprom_regfile #(.AW(AW), .DW(DW)) u_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (wr_valid_o && wr_ready_i),
    .waddr_i (wr_addr_o),
    .wdata_i (wr_data_o),
    .raddr_i (rd_addr),
    .rdata_o (rd_data)
  );
endmodule

// File: tb/test_eeprom_i2c_slave.sv
`timescale 1ns/1ps
module test_eeprom_i2c_slave;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_low = 1'b0;
  logic [2:0] strap = 3'b101;
  logic busy = 1'b0;
  logic ready = 1'b1;
  logic sda_oe;
  logic wr_valid;
  logic [6:0] wr_addr;
  logic [7:0] wr_data;
  logic sda_line;

  int checks = 0;
  int errors = 0;
  int glitches = 0;
  int log_n = 0;
  logic [6:0] log_addr [64];
  logic [7:0] log_data [64];

  always #2.5 clk = ~clk;
  assign sda_line = !(m_low || sda_oe);

  eeprom_i2c_slave i_eeprom_i2c_slave (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl),
    .sda_i      (sda_line),
    .strap_i    (strap),
    .busy_i     (busy),
    .sda_oe_o   (sda_oe),
    .wr_valid_o (wr_valid),
    .wr_ready_i (ready),
    .wr_addr_o  (wr_addr),
    .wr_data_o  (wr_data)
  );

  always @(posedge clk) begin
    if (wr_valid && ready && log_n < 64) begin
      log_addr[log_n] <= wr_addr;
      log_data[log_n] <= wr_data;
      log_n <= log_n + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic qtr();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_low = 1'b0; qtr();
    scl = 1'b1;   qtr();
    m_low = 1'b1; qtr();
    scl = 1'b0;   qtr();
  endtask

  task automatic bus_stop();
    m_low = 1'b1; qtr();
    scl = 1'b1;   qtr();
    m_low = 1'b0; qtr(); qtr();
  endtask

  task automatic send_bit(input bit b);
    m_low = !b; qtr();
    scl = 1'b1; qtr(); qtr();
    scl = 1'b0; qtr();
  endtask

  task automatic recv_bit(output bit b);
    bit s1;
    m_low = 1'b0; qtr();
    scl = 1'b1; qtr();
    s1 = sda_line; qtr();
    b = sda_line;
    if (s1 != b) glitches++;
    scl = 1'b0; qtr();
  endtask

  task automatic send_byte(input logic [7:0] v, output bit ack);
    bit b;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    recv_bit(b);
    ack = !b;
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] v);
    bit b;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      v[i] = b;
    end
    send_bit(!mack);
    m_low = 1'b0;
  endtask

  function automatic logic [7:0] sel(input logic [2:0] s, input bit rd);
    return {4'b1010, s, rd};
  endfunction

  task automatic expect_ack(input logic [7:0] v, input bit exp, input string tag);
    bit ack;
    send_byte(v, ack);
    check(ack == exp, tag, ack, exp);
  endtask

  task automatic expect_read(input bit mack, input logic [7:0] exp, input string tag);
    logic [7:0] v;
    recv_byte(mack, v);
    check(v == exp, tag, v, exp);
  endtask

  task automatic t_reset();
    check(sda_oe == 1'b0, "R2 reset sda released", sda_oe, 0);
    check(wr_valid == 1'b0, "R4 reset no request", wr_valid, 0);
  endtask

  task automatic t_bad_select();
    int n0 = log_n;
    bus_start();
    expect_ack(sel(3'b011, 1'b0), 1'b0, "R1 strap mismatch no ack");
    expect_ack(8'h12, 1'b0, "R2 ignored after mismatch");
    bus_start();
    expect_ack({4'b0110, strap, 1'b0}, 1'b0, "R1 type mismatch no ack");
    bus_stop();
    check(log_n == n0, "R2 no request after mismatch", log_n, n0);
  endtask

  task automatic t_write_burst();
    logic [7:0] d [4] = '{8'h3C, 8'hA5, 8'h5A, 8'h96};
    int n0 = log_n;
    bus_start();
    expect_ack(sel(strap, 1'b0), 1'b1, "R2 write select ack");
    expect_ack(8'h10, 1'b1, "R3 address ack");
    for (int i = 0; i < 4; i++) expect_ack(d[i], 1'b1, "R3 data ack");
    bus_stop();
    check(log_n == n0 + 4, "R3 request count", log_n, n0 + 4);
    for (int i = 0; i < 4; i++) begin
      check(log_addr[n0+i] == 7'h10 + 7'(i), "R3 request address", log_addr[n0+i], 7'h10 + i);
      check(log_data[n0+i] == d[i], "R3 request data", log_data[n0+i], d[i]);
    end
  endtask

  task automatic random_setup(input logic [7:0] a);
    bus_start();
    expect_ack(sel(strap, 1'b0), 1'b1, "R6 dummy write select ack");
    expect_ack(a, 1'b1, "R6 address ack");
    bus_start();
    expect_ack(sel(strap, 1'b1), 1'b1, "R6 read select ack");
  endtask

  task automatic t_random_seq();
    random_setup(8'h10);
    expect_read(1'b1, 8'h3C, "R6 random read data");
    expect_read(1'b1, 8'hA5, "R7 sequential byte 2");
    expect_read(1'b0, 8'h5A, "R7 sequential byte 3");
    qtr();
    check(sda_oe == 1'b0, "R7 released after no-ack", sda_oe, 0);
    bus_stop();
  endtask

  task automatic t_current();
    bus_start();
    expect_ack(sel(strap, 1'b1), 1'b1, "R5 read select ack");
    expect_read(1'b0, 8'h96, "R5 current address data");
    bus_stop();
  endtask

  task automatic t_wrap();
    int n0 = log_n;
    bus_start();
    expect_ack(sel(strap, 1'b0), 1'b1, "R3 write select ack");
    expect_ack(8'hFF, 1'b1, "R3 address ack msb set");
    expect_ack(8'h11, 1'b1, "R3 data ack");
    expect_ack(8'h22, 1'b1, "R3 data ack");
    bus_stop();
    check(log_addr[n0] == 7'h7F, "R3 msb ignored address", log_addr[n0], 7'h7F);
    check(log_addr[n0+1] == 7'h00, "R3 write counter wraps", log_addr[n0+1], 0);
    random_setup(8'h7F);
    expect_read(1'b1, 8'h11, "R7 read at 127");
    expect_read(1'b0, 8'h22, "R7 read wraps to 0");
    bus_stop();
  endtask

  task automatic t_busy();
    busy = 1'b1;
    bus_start();
    expect_ack(sel(strap, 1'b1), 1'b0, "R10 busy no ack");
    bus_stop();
    busy = 1'b0;
    bus_start();
    expect_ack(sel(strap, 1'b1), 1'b1, "R10 ack after busy");
    expect_read(1'b0, 8'h00, "R5 current read after wrap");
    bus_stop();
  endtask

  task automatic t_abort();
    bus_start();
    expect_ack(sel(strap, 1'b0), 1'b1, "R9 select ack");
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
    random_setup(8'h12);
    expect_read(1'b0, 8'h5A, "R9 read after abort");
    bus_stop();
    for (int i = 7; i >= 0; i--) send_bit(sel(strap, 1'b1) >> i);
    begin
      bit b;
      recv_bit(b);
      check(b == 1'b1, "R9 silent after stop", b, 1);
    end
  endtask

  task automatic t_backpressure();
    ready = 1'b0;
    bus_start();
    expect_ack(sel(strap, 1'b0), 1'b1, "R4 select ack");
    expect_ack(8'h20, 1'b1, "R4 address ack");
    expect_ack(8'h77, 1'b1, "R4 first byte ack");
    expect_ack(8'h88, 1'b0, "R4 second byte no ack");
    bus_stop();
    check(wr_valid == 1'b1, "R4 valid held", wr_valid, 1);
    check(wr_addr == 7'h20, "R4 address held", wr_addr, 7'h20);
    check(wr_data == 8'h77, "R4 data held", wr_data, 8'h77);
    ready = 1'b1;
    qtr();
    check(wr_valid == 1'b0, "R4 valid drops after accept", wr_valid, 0);
    random_setup(8'h20);
    expect_read(1'b1, 8'h77, "R4 accepted byte stored");
    expect_read(1'b0, 8'h00, "R4 dropped byte not stored");
    bus_stop();
  endtask

  task automatic t_strap();
    strap = 3'b010;
    bus_start();
    expect_ack(sel(3'b101, 1'b1), 1'b0, "R1 old strap no ack");
    bus_start();
    expect_ack(sel(3'b010, 1'b1), 1'b1, "R1 new strap ack");
    expect_read(1'b0, 8'h00, "R5 read with new strap");
    bus_stop();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    qtr();
    t_reset();
    t_bad_select();
    t_write_burst();
    t_random_seq();
    t_current();
    t_wrap();
    t_busy();
    t_abort();
    t_backpressure();
    t_strap();
    check(glitches == 0, "R8 SDA stable while SCL high", glitches, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule